// File: doc/BRIEF.md
# Three-Lane Seven-to-One Pixel Link Serializer

This block is the digital core of a flat-panel pixel link transmitter. Once per pixel clock period it takes one pixel: six bits each of red, green and blue, plus line sync, frame sync and data enable, 21 bits in all. It sends those bits out over three serial data lanes, seven bits per lane per period. A fourth lane carries a forwarded clock pattern that stays in phase with the pixel clock, so the far end can recover the framing. The phase-locked multiplier sits outside the block. It supplies a bit clock at seven times the pixel rate, aligned to the pixel clock, and the block samples the pixel clock with that bit clock.

A pixel is captured where the pixel clock is seen falling. It is held in a shadow register and moved into the lane shifters at the start of the next pixel period, so a change on the pixel inputs between captures can never mix two pixels on the wire. The block drives its four lane bits together with one pad drive enable. When the enable is low, the pad cells put all four lanes into high impedance.

Pulling the active-low power-down input low drops the drive enable at once. After power-down ends, the enable stays low until a complete pixel captured after the return is ready to go out.

Top module: `pixlink_ser7`

## Requirements
- R1: The 21-bit pixel word is packed as red in bits 0 to 5, green in bits 6 to 11, blue in bits 12 to 17, line sync in bit 18, frame sync in bit 19 and data enable in bit 20. Lane k carries word bits 7k to 7k+6.
- R2: A pixel is captured at the first bit-clock rising edge at which `pix_clk` is sampled low after having been sampled high. Input values present at any other bit-clock edge are never transmitted.
- R3: In each pixel period, lane k shows word bit 7k+s in bit slot s, for s = 0 to 6. Each slot lasts one bit-clock cycle, and slot 0 comes first.
- R4: A pixel captured at one falling edge is transmitted in the period that starts at the next detected falling edge. Slot 0 is valid from that edge.
- R5: The forwarded clock lane is 1 in slots 0 to 3 and 0 in slots 4 to 6 of every period.
- R6: While `pd_n` is low, `drv_en_o` is 0 in the same cycle, and all lane and clock outputs are 0.
- R7: After `pd_n` returns high, `drv_en_o` rises only at the second detected falling edge, when the first pixel captured after the return starts transmission.
- R8: While `rst_n` is low, `drv_en_o`, `lane_o` and `fclk_o` are 0. After reset, the enable again waits for the second detected falling edge.
- R9: Changes on the pixel inputs between captures do not alter the pixel currently being serialized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock at seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| pd_n | input | 1 | Active-low power-down |
| pix_clk | input | 1 | Pixel clock; its falling edge is the capture strobe |
| red_i | input | 6 | Red colour bits |
| grn_i | input | 6 | Green colour bits |
| blu_i | input | 6 | Blue colour bits |
| line_sync_i | input | 1 | Line sync control bit |
| frame_sync_i | input | 1 | Frame sync control bit |
| data_en_i | input | 1 | Data enable control bit |
| lane_o | output | 3 | Serial data lane bits, one per lane |
| fclk_o | output | 1 | Forwarded clock lane bit |
| drv_en_o | output | 1 | Pad drive enable; 0 puts all four lanes in high impedance |

## Verification
The assertions assume that `pix_clk` and the pixel inputs change only away from the rising edge of `bit_clk`. They also assume the pixel clock is phase-locked to the bit clock, with exactly seven bit cycles between falling edges, so the slot counter never wraps on its own. The bench meets these conditions by driving every input on the falling edge of the bit clock. Its pixel clock is high for four bit cycles and low for three. The pixel inputs are given fresh random values on every bit cycle, not only at capture, so the no-tearing rule is stressed by constant input churn. Power-down is applied once as a long window and once as a single-cycle pulse.

// File: rtl/pixlink_pkg.sv
package pixlink_pkg;
  // default geometry of the link
  localparam int unsigned COLOR_W_DEF  = 6;
  localparam int unsigned LANES_DEF    = 3;
  localparam int unsigned SLOTS_DEF    = 7;
  localparam int unsigned CLK_HIGH_DEF = 4;
endpackage

// File: rtl/pixlink_rst_sync.sv
module pixlink_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pixlink_front.sv
module pixlink_front #(
  parameter int unsigned WORD_W   = 21,
  parameter int unsigned SLOTS    = 7,
  parameter int unsigned CLK_HIGH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              pix_clk,
  input  logic [WORD_W-1:0] word_i,
  output logic              load_o,
  output logic [WORD_W-1:0] shadow_o,
  output logic              fclk_o,
  output logic              live_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] HIGH_LIM  = SLOT_W'(CLK_HIGH);

  logic              pclk_q;
  logic              fall_w;
  logic [WORD_W-1:0] shadow_q, shadow_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              fclk_q, fclk_d;
  logic              have_q, have_d;
  logic              live_q, live_d;

  // falling edge of the pixel clock seen at bit-clock resolution
  assign fall_w = pclk_q & ~pix_clk;

  always_comb begin
    shadow_d = shadow_q;
    if (fall_w) shadow_d = word_i;

    if (fall_w)                 slot_d = '0;
    else if (slot_q == LAST_SLOT) slot_d = '0;
    else                        slot_d = slot_q + 1'b1;

    fclk_d = (slot_d < HIGH_LIM);

    have_d = have_q;
    live_d = live_q;
    if (!pd_n) begin
      have_d = 1'b0;
      live_d = 1'b0;
    end else if (fall_w) begin
      have_d = 1'b1;
      if (have_q) live_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q   <= 1'b0;
      shadow_q <= '0;
      slot_q   <= LAST_SLOT;
      fclk_q   <= 1'b0;
      have_q   <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      pclk_q   <= pix_clk;
      shadow_q <= shadow_d;
      slot_q   <= slot_d;
      fclk_q   <= fclk_d;
      have_q   <= have_d;
      live_q   <= live_d;
    end
  end

  assign load_o   = fall_w;
  assign shadow_o = shadow_q;
  assign fclk_o   = fclk_q;
  assign live_o   = live_q;

  // R4: a detected edge restarts the period at slot 0
  a_r4_slot_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> (slot_q == '0));
  // R5: forwarded clock only rises at the start of a period
  a_r5_fclk_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fclk_q) |-> (slot_q == '0));
  // R9: shadow holds between captures
  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_w |=> $stable(shadow_q));
  // R7: enable rises only on an edge with a word already captured
  a_r7_live_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live_q) |-> $past(have_q && fall_w && pd_n));
  // R6: power-down drops the drive state
  a_r6_pd_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> !live_q);
endmodule

// File: rtl/pixlink_lane.sv
module pixlink_lane #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SLOTS-1:0] par_i,
  output logic             ser_o
);
  logic [SLOTS-1:0] sh_q, sh_d;

  always_comb begin
    if (load_i) sh_d = par_i;
    else        sh_d = {1'b0, sh_q[SLOTS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign ser_o = sh_q[0];

  // R3: slot 0 of a loaded word is its lowest bit
  a_r3_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ser_o == $past(par_i[0])));
endmodule

// File: rtl/pixlink_ser7.sv
module pixlink_ser7 #(
  parameter int unsigned COLOR_W  = pixlink_pkg::COLOR_W_DEF,
  parameter int unsigned LANES    = pixlink_pkg::LANES_DEF,
  parameter int unsigned SLOTS    = pixlink_pkg::SLOTS_DEF,
  parameter int unsigned CLK_HIGH = pixlink_pkg::CLK_HIGH_DEF
) (
  input  logic               bit_clk,
  input  logic               rst_n,
  input  logic               pd_n,
  input  logic               pix_clk,
  input  logic [COLOR_W-1:0] red_i,
  input  logic [COLOR_W-1:0] grn_i,
  input  logic [COLOR_W-1:0] blu_i,
  input  logic               line_sync_i,
  input  logic               frame_sync_i,
  input  logic               data_en_i,
  output logic [LANES-1:0]   lane_o,
  output logic               fclk_o,
  output logic               drv_en_o
);
  // LANES * SLOTS must equal the packed word width
  localparam int unsigned WORD_W = 3 * COLOR_W + 3;

  logic              rst_ns;
  logic [WORD_W-1:0] word_w;
  logic              load_w;
  logic [WORD_W-1:0] shadow_w;
  logic              fclk_w;
  logic              live_w;
  logic [LANES-1:0]  ser_w;

  // R1: word packing
  assign word_w = {data_en_i, frame_sync_i, line_sync_i, blu_i, grn_i, red_i};

  pixlink_rst_sync #(.STAGES(2)) u_rst (
    .clk(bit_clk), .rst_n_async(rst_n), .rst_n_sync(rst_ns)
  );

  pixlink_front #(.WORD_W(WORD_W), .SLOTS(SLOTS), .CLK_HIGH(CLK_HIGH)) u_front (
    .clk(bit_clk), .rst_n(rst_ns), .pd_n(pd_n), .pix_clk(pix_clk),
    .word_i(word_w), .load_o(load_w), .shadow_o(shadow_w),
    .fclk_o(fclk_w), .live_o(live_w)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pixlink_lane #(.SLOTS(SLOTS)) u_lane (
      .clk(bit_clk), .rst_n(rst_ns), .load_i(load_w),
      .par_i(shadow_w[k*SLOTS +: SLOTS]), .ser_o(ser_w[k])
    );
  end

  assign drv_en_o = live_w & pd_n;
  assign lane_o   = drv_en_o ? ser_w : '0;
  assign fclk_o   = drv_en_o & fclk_w;

  // R6: disabled pads carry no activity
  a_r6_quiet: assert property (@(posedge bit_clk) disable iff (!rst_ns)
    !drv_en_o |-> (lane_o == '0 && !fclk_o));
endmodule

// File: tb/pixlink_ser7_tb_top.sv
module pixlink_ser7_tb_top;
  localparam int RUN = 300;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, pd_n, pix_clk;
  logic [5:0] red, grn, blu;
  logic       ls, fs, de;
  logic [2:0] lane;
  logic       fclk, en;

  pixlink_ser7 dut_i (
    .bit_clk(clk), .rst_n(rst_n), .pd_n(pd_n), .pix_clk(pix_clk),
    .red_i(red), .grn_i(grn), .blu_i(blu),
    .line_sync_i(ls), .frame_sync_i(fs), .data_en_i(de),
    .lane_o(lane), .fclk_o(fclk), .drv_en_o(en)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // R1 packing, as stated in the requirement
  function automatic logic [20:0] pack_now();
    return {de, fs, ls, blu, grn, red};
  endfunction

  // behavioural model state
  bit          m_prev;
  int          m_slot;
  bit          m_live;
  logic [20:0] m_cur;
  logic [20:0] pend[$];

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pd_n = 1'b1; pix_clk = 1'b1;
    {de, fs, ls, blu, grn, red} = '0;
    m_prev = 1'b1; m_slot = 0; m_live = 1'b0; m_cur = '0;
    for (int t = 0; t < RUN; t++) begin
      @(negedge clk);
      // model update for the rising edge just passed
      if (!rst_n) begin
        m_live = 1'b0;
        pend.delete();
        m_prev = 1'b1;
      end else begin
        bit fall;
        fall = m_prev && !pix_clk;
        m_prev = pix_clk;
        if (!pd_n) begin
          pend.delete();
          m_live = 1'b0;
        end
        if (fall) begin
          m_slot = 0;
          if (pd_n) begin
            if (pend.size() != 0) begin
              m_cur = pend.pop_front();
              m_live = 1'b1;
            end
            pend.push_back(pack_now());
          end
        end else begin
          m_slot = (m_slot + 1) % 7;
        end
      end
      // compare
      begin
        logic       e_en;
        logic [2:0] e_lane;
        logic       e_fclk;
        e_en = m_live && pd_n && rst_n;
        for (int k = 0; k < 3; k++) e_lane[k] = e_en ? m_cur[k*7 + m_slot] : 1'b0;
        e_fclk = e_en ? (m_slot < 4) : 1'b0;
        if (t < 10)     chk("R8 enable", 32'(en), 32'(e_en));
        else if (!pd_n) chk("R6 enable", 32'(en), 32'(e_en));
        else            chk("R7 enable", 32'(en), 32'(e_en));
        chk("R1 R2 R3 R4 R9 lanes", 32'(lane), 32'(e_lane));
        chk("R5 fclk", 32'(fclk), 32'(e_fclk));
      end
      // drive next inputs
      rst_n = (t >= 3);
      if (t >= 9) pix_clk = (((t - 9) % 7) < 4);
      pd_n = !((t >= 120 && t <= 134) || t == 200);
      {de, fs, ls, blu, grn, red} = 21'($urandom);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule